// File: doc/BRIEF.md
# Five-Pin Bidirectional GPIO Port

This block controls a small general-purpose I/O port of five pins. Software reaches it over a byte-wide register bus with three decoded addresses. The first sets each pin's direction. The second holds the output latch values. The third is a read-only view that mixes the latched output for driven pins with the synchronised live level for input pins. Every pin gets a per-pin output value and output-enable for an external tri-state pad.

There are two reset classes. The asynchronous reset and the hardware-standby request clear both registers. The partial-reset request turns every pin back into an input but keeps the output latch. While the memory-interface enable is high, pin 0 is handed to an external strobe signal. Its register bits stay writable during that time and apply again once the enable is released.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, both registers are zero, pin_oe_o is all zero, and reads of addresses 0 and 1 return 0x00.
- R2: A write with addr_i=0 loads wdata_i[4:0] into the direction register on that clock edge. A read of address 0 returns {3'b000, direction}.
- R3: A write with addr_i=1 loads wdata_i[4:0] into the data register on that clock edge. A read of address 1 returns {3'b000, data}, so bits 7:5 always read 0 and writes to them have no effect.
- R4: A write with addr_i=2 (port view) changes neither register.
- R5: For every pin not taken over by the strobe, pin_oe_o equals the direction bit (1 means output) and pin_o equals the data bit.
- R6: A read of address 2 returns, for each bit i, the data bit when direction bit i is 1. When direction bit i is 0, it returns the pin_i[i] level sampled two clock edges earlier. Bits 7:5 read 0.
- R7: A clock edge with hw_stby_i high clears both registers, whatever the write inputs are.
- R8: A clock edge with part_rst_i high and hw_stby_i low clears the direction register, leaves the data register unchanged, and ignores any write.
- R9: While mem_if_en_i is high, pin_o[0] equals strobe_i and pin_oe_o[0] is 1.
- R10: Writes to direction bit 0 and data bit 0 are accepted while mem_if_en_i is high. After release, pin 0 follows them.
- R11: Address 3 reads 0x00, and writes to it change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low full reset |
| hw_stby_i | input | 1 | Synchronous full clear (hardware standby) |
| part_rst_i | input | 1 | Synchronous partial reset, keeps data latch |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 direction, 1 data, 2 port view |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for addr_i |
| pin_i | input | 5 | Pin levels from the pads |
| pin_o | output | 5 | Pin output values |
| pin_oe_o | output | 5 | Pin output enables, 1 drives the pad |
| mem_if_en_i | input | 1 | Hands pin 0 to the external strobe |
| strobe_i | input | 1 | Strobe value from the memory controller |

## Verification
Register writes and both reset requests act at the clock edge that samples them, so their effect is due in the first read and in the pin outputs after that edge. A change on pin_i shows in the port view only after two edges. The strobe takeover and the read decode are combinational in the same cycle. The bench drives inputs and checks at the falling edge. Its reference model advances the registers and a two-entry sample history at each rising edge, so each expected value is compared in exactly the cycle it is due.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned NUM_PINS = 5;
  localparam int unsigned BUS_W    = 8;
  localparam int unsigned ADDR_W   = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_DIR  = 2'd0,
    ADDR_DATA = 2'd1,
    ADDR_PORT = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned N = NUM_PINS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hw_stby_i,
  input  logic                part_rst_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [N-1:0]        wdata_i,
  output logic [N-1:0]        dir_o,
  output logic [N-1:0]        data_o
);
  logic [N-1:0] dir_q, data_q;
  logic         wr_ok;

  assign wr_ok = wr_en_i && !hw_stby_i && !part_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
    end else if (hw_stby_i || part_rst_i) begin
      dir_q <= '0;
    end else if (wr_ok && addr_i == ADDR_DIR) begin
      dir_q <= wdata_i;
    end
  end

  // data latch survives the partial reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (hw_stby_i) begin
      data_q <= '0;
    end else if (wr_ok && addr_i == ADDR_DATA) begin
      data_q <= wdata_i;
    end
  end

  assign dir_o  = dir_q;
  assign data_o = data_q;
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned N       = 5,
  parameter int unsigned ALT_PIN = 0
) (
  input  logic [N-1:0] dir_i,
  input  logic [N-1:0] data_i,
  input  logic [N-1:0] pin_sync_i,
  input  logic         alt_en_i,
  input  logic         alt_val_i,
  output logic [N-1:0] pin_o,
  output logic [N-1:0] pin_oe_o,
  output logic [N-1:0] port_view_o
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    assign port_view_o[i] = dir_i[i] ? data_i[i] : pin_sync_i[i];
    if (i == ALT_PIN) begin : g_alt
      assign pin_o[i]    = alt_en_i ? alt_val_i : data_i[i];
      assign pin_oe_o[i] = alt_en_i | dir_i[i];
    end else begin : g_plain
      assign pin_o[i]    = data_i[i];
      assign pin_oe_o[i] = dir_i[i];
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned N      = NUM_PINS,
  parameter int unsigned DW     = BUS_W,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_stby_i,
  input  logic              part_rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [N-1:0]      pin_i,
  output logic [N-1:0]      pin_o,
  output logic [N-1:0]      pin_oe_o,
  input  logic              mem_if_en_i,
  input  logic              strobe_i
);
  localparam int unsigned PAD_W = DW - N;

  logic [N-1:0] dir_q, data_q, pin_sync, port_view;

  gpio_sync #(.WIDTH(N), .STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  gpio_regs #(.N(N)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hw_stby_i (hw_stby_i),
    .part_rst_i(part_rst_i),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i[N-1:0]),
    .dir_o     (dir_q),
    .data_o    (data_q)
  );

  gpio_pad_ctrl #(.N(N), .ALT_PIN(0)) u_pad (
    .dir_i      (dir_q),
    .data_i     (data_q),
    .pin_sync_i (pin_sync),
    .alt_en_i   (mem_if_en_i),
    .alt_val_i  (strobe_i),
    .pin_o      (pin_o),
    .pin_oe_o   (pin_oe_o),
    .port_view_o(port_view)
  );

  always_comb begin
    unique case (addr_i)
      ADDR_DIR:  rdata_o = {{PAD_W{1'b0}}, dir_q};
      ADDR_DATA: rdata_o = {{PAD_W{1'b0}}, data_q};
      ADDR_PORT: rdata_o = {{PAD_W{1'b0}}, port_view};
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int unsigned N  = NUM_PINS,
  parameter int unsigned DW = BUS_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hw_stby_i,
  input logic              part_rst_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     rdata_o,
  input logic [N-1:0]      pin_o,
  input logic [N-1:0]      pin_oe_o,
  input logic              mem_if_en_i,
  input logic              strobe_i,
  input logic [N-1:0]      dir_q,
  input logic [N-1:0]      data_q
);
  logic quiet;
  assign quiet = !hw_stby_i && !part_rst_i;

  p_dir_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && quiet && addr_i == ADDR_DIR |=> dir_q == $past(wdata_i[N-1:0]));

  p_data_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && quiet && addr_i == ADDR_DATA |=> data_q == $past(wdata_i[N-1:0]));

  p_reserved_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DW-1:N] == '0);

  p_port_wr_discard_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && quiet && addr_i == ADDR_PORT |=> $stable(dir_q) && $stable(data_q));

  p_oe_follows_dir_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_oe_o[N-1:1] == dir_q[N-1:1] && pin_o[N-1:1] == data_q[N-1:1]);

  p_hw_stby_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_stby_i |=> dir_q == '0 && data_q == '0);

  p_part_rst_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    part_rst_i && !hw_stby_i |=> dir_q == '0 && data_q == $past(data_q));

  p_alt_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_if_en_i |-> pin_oe_o[0] && pin_o[0] == strobe_i);

  p_unmapped_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == ADDR_NONE |-> rdata_o == '0);
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.N(N), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hw_stby_i  (hw_stby_i),
  .part_rst_i (part_rst_i),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .pin_o      (pin_o),
  .pin_oe_o   (pin_oe_o),
  .mem_if_en_i(mem_if_en_i),
  .strobe_i   (strobe_i),
  .dir_q      (dir_q),
  .data_q     (data_q)
);

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hw_stby_i = 1'b0, part_rst_i = 1'b0, wr_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic [4:0] pin_i = 5'h00;
  logic [4:0] pin_o, pin_oe_o;
  logic       mem_if_en_i = 1'b0, strobe_i = 1'b0;

  int checks = 0, errors = 0;
  int m_dir = 0, m_data = 0, m_s1 = 0, m_s2 = 0;

  always #4 clk_i = ~clk_i;

  gpio_port_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .hw_stby_i(hw_stby_i), .part_rst_i(part_rst_i),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
    .mem_if_en_i(mem_if_en_i), .strobe_i(strobe_i)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_rdata();
    int v = 0;
    case (addr_i)
      2'd0: v = m_dir;
      2'd1: v = m_data;
      2'd2: for (int i = 0; i < 5; i++)
              v |= ((m_dir >> i) & 1) ? (m_data & (1 << i)) : (m_s2 & (1 << i));
      default: v = 0;
    endcase
    return v;
  endfunction

  // advance one clock and compare at the falling edge
  task automatic step(string tag);
    @(posedge clk_i);
    if (!rst_ni) begin
      m_dir = 0; m_data = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      if (hw_stby_i) begin m_dir = 0; m_data = 0; end
      else if (part_rst_i) m_dir = 0;
      else if (wr_en_i && addr_i == 2'd0) m_dir = wdata_i & 8'h1F;
      else if (wr_en_i && addr_i == 2'd1) m_data = wdata_i & 8'h1F;
      m_s2 = m_s1;
      m_s1 = pin_i;
    end
    @(negedge clk_i);
    begin
      int eoe = m_dir, eo = m_data;
      if (mem_if_en_i) begin
        eoe |= 1;
        eo = (eo & 8'h1E) | strobe_i;
      end
      check(tag, "rdata_o", rdata_o, exp_rdata());
      check(tag, "pin_oe_o", pin_oe_o, eoe);
      check(tag, "pin_o", pin_o, eo);
    end
  endtask

  task automatic wr(string tag, logic [1:0] a, logic [7:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    step(tag);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(string tag, logic [1:0] a);
    addr_i = a;
    step(tag);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    rd("R1", 2'd0); rd("R1", 2'd1);
    @(negedge clk_i) rst_ni = 1'b1;
    rd("R1", 2'd0); rd("R1", 2'd1);
    // R2 direction write, reserved bits dropped
    wr("R2", 2'd0, 8'hFF); rd("R2", 2'd0);
    // R3 data write
    wr("R3", 2'd1, 8'hEA); rd("R3", 2'd1);
    // R4 port write discarded
    wr("R4", 2'd2, 8'h15); rd("R4", 2'd0); rd("R4", 2'd1);
    // R5 outputs, R6 mixed port view with pin changes
    wr("R5", 2'd0, 8'h05);
    addr_i = 2'd2; pin_i = 5'h1A;
    rd("R6", 2'd2); rd("R6", 2'd2); rd("R6", 2'd2);
    pin_i = 5'h05; rd("R6", 2'd2); rd("R6", 2'd2);
    wr("R6", 2'd0, 8'h00); rd("R6", 2'd2);
    // R9 strobe takeover, R10 writes during takeover
    mem_if_en_i = 1'b1;
    for (int k = 0; k < 4; k++) begin strobe_i = k[0]; rd("R9", 2'd2); end
    wr("R10", 2'd0, 8'h01); wr("R10", 2'd1, 8'h00); wr("R10", 2'd1, 8'h01);
    strobe_i = 1'b0; rd("R10", 2'd1);
    mem_if_en_i = 1'b0; rd("R10", 2'd0);
    wr("R10", 2'd1, 8'h00); rd("R10", 2'd1);
    // R8 partial reset keeps data, blocks write
    wr("R8", 2'd0, 8'h1F); wr("R8", 2'd1, 8'h13);
    part_rst_i = 1'b1; wr("R8", 2'd1, 8'h04); part_rst_i = 1'b0;
    rd("R8", 2'd1); rd("R8", 2'd0);
    // R7 hardware standby clears both
    wr("R7", 2'd0, 8'h0F);
    hw_stby_i = 1'b1; wr("R7", 2'd0, 8'h1F); hw_stby_i = 1'b0;
    rd("R7", 2'd1); rd("R7", 2'd0);
    // R11 unmapped address
    wr("R11", 2'd1, 8'h09); wr("R11", 2'd3, 8'h1F); rd("R11", 2'd3);
    rd("R11", 2'd1); rd("R11", 2'd0);
    // mixed traffic
    for (int k = 0; k < 300; k++) begin
      int r = $urandom;
      wr_en_i = r[0]; addr_i = r[2:1]; wdata_i = r[10:3];
      pin_i = r[15:11]; mem_if_en_i = r[16] & r[17]; strobe_i = r[18];
      part_rst_i = (r[23:19] == 0); hw_stby_i = (r[28:24] == 0);
      step("R5");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule